// File: doc/BRIEF.md
# Configuration Start-up Release Sequencer

This block closes out device configuration and hands the device over to user mode. It runs on a single start-up clock and watches two inputs: a configuration-done level and an external reset pad. Once configuration is reported complete, it counts start-up cycles and releases three outputs, each at its own programmed cycle index. The outputs are the active-low global set/reset, the I/O enable and the external DONE indication. Any two or all three indices may be equal.

The reset pad is brought into the start-up clock domain through a two-flop synchronizer. While the device is still configuring or sequencing, a press of the pad aborts the sequence and reports the abort on a one-cycle status pulse. Once the global set/reset has been released, its level is taken from one of three sources picked by a two-bit select. In the disabled mode, which is the default encoding 00, it stays inactive. The other two modes follow the pad or follow an internally routed request. When the pad is not the chosen source, it only appears on an ordinary input-report output.

The state machine has three states. ST_CONFIG is configuration in progress. ST_STARTUP is the counted release window. ST_USER is user mode. Five transitions connect them. *begin* (ST_CONFIG to ST_STARTUP) fires when done is high and the synchronized pad is low. *finish* (ST_STARTUP to ST_USER) fires when all three events have been released. *abort* (ST_CONFIG or ST_STARTUP to ST_CONFIG) fires on a synchronized pad rise. *withdraw* (ST_STARTUP to ST_CONFIG) fires when done drops. *reconfigure* (ST_USER to ST_CONFIG) fires when done drops.

Top module: `startup_seq`

## Requirements
- R1: While `cfg_done` is low, after reset or after any return to ST_CONFIG, `gsr_n` is 0, `io_en` is 0 and `done_out` is 0.
- R2: The sequence starts at the first rising edge at which `cfg_done` is 1 and the synchronized pad is 0. That edge is edge 0. An event with index k (0 to 7) takes effect just after edge k+1. `gsr_n` leaves 0, `io_en` becomes 1 and `done_out` becomes 1, each at its own index.
- R3: Events that share an index are released on the same edge.
- R4: `rst_pad` passes through two synchronizer flops. A rising edge of the synchronized pad while the state is not ST_USER does three things: it clears the count, it returns all outputs to their R1 values, and it raises `abort_pulse` for exactly one cycle. A pad that rises before edge n causes the abort at edge n+2.
- R5: After the global set/reset is released, `gsr_sel` picks its source. 00 or 11 gives `gsr_n`=1. 01 gives `gsr_n` equal to the inverse of the synchronized pad. 10 gives `gsr_n` equal to the inverse of `gsr_int`.
- R6: Released outputs stay released until an abort or until `cfg_done` goes low. The count stops once all three events are out, and the block stays in ST_USER.
- R7: When `gsr_sel` is not 01, the pad has no effect on `gsr_n`, `io_en`, `done_out` or `abort_pulse` in ST_USER, and `pad_user` shows the synchronized pad. When `gsr_sel` is 01, `pad_user` is 0.
- R8: `cfg_done` low in ST_STARTUP or ST_USER returns the block to ST_CONFIG without an abort pulse.
- R9: While the synchronized pad is high in ST_CONFIG, the sequence does not start, even with `cfg_done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_done | input | 1 | Configuration complete level |
| rst_pad | input | 1 | External reset pad, active high, asynchronous |
| gsr_sel | input | 2 | Global set/reset source after release |
| gsr_int | input | 1 | Internally routed set/reset request, active high |
| idx_gsr | input | 3 | Release cycle index of the global set/reset |
| idx_io | input | 3 | Release cycle index of the I/O enable |
| idx_done | input | 3 | Release cycle index of external DONE |
| gsr_n | output | 1 | Global set/reset, active low |
| io_en | output | 1 | I/O enable |
| done_out | output | 1 | External DONE indication |
| abort_pulse | output | 1 | One-cycle abort report |
| pad_user | output | 1 | Synchronized pad as an ordinary input |

## Verification
A stuck or misordered state appears at the ports within one start-up cycle. Two examples: a release that lands one edge early or late, and a release output that fails to fall together with the others on an abort. A wrong count or a lost sticky flag shows up no later than eight cycles after the sequence begins, as a missing or premature `done_out` or `io_en`. A fault in the synchronizer depth moves `abort_pulse` and a pad-sourced `gsr_n` by a cycle. The bench compares every output on every cycle against a behavioural model, so any of these faults is caught on the first divergent cycle.

// File: rtl/startup_pkg.sv
package startup_pkg;
    typedef enum logic [1:0] {
        ST_CONFIG  = 2'd0,
        ST_STARTUP = 2'd1,
        ST_USER    = 2'd2
    } su_state_e;

    typedef enum logic [1:0] {
        GSR_OFF    = 2'b00,
        GSR_PAD    = 2'b01,
        GSR_ROUTED = 2'b10,
        GSR_OFF_B  = 2'b11
    } gsr_src_e;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic pad_s,
    output logic pad_rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pad_in};
    end

    assign pad_s    = chain[STAGES-1];
    assign pad_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/release_slot.sv
module release_slot #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] idx,
    output logic             hit,
    output logic             released
);
    assign hit = run && (cnt == idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     released <= 1'b0;
        else if (clear) released <= 1'b0;
        else if (hit)   released <= 1'b1;
    end
endmodule

// File: rtl/gsr_mux.sv
module gsr_mux
    import startup_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       released,
    input  logic       pad_s,
    input  logic       routed,
    output logic       gsr_n
);
    always_comb begin
        if (!released) begin
            gsr_n = 1'b0;
        end else begin
            unique case (gsr_src_e'(sel))
                GSR_PAD:    gsr_n = ~pad_s;
                GSR_ROUTED: gsr_n = ~routed;
                default:    gsr_n = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  logic             rst_pad,
    input  logic [1:0]       gsr_sel,
    input  logic             gsr_int,
    input  logic [CNT_W-1:0] idx_gsr,
    input  logic [CNT_W-1:0] idx_io,
    input  logic [CNT_W-1:0] idx_done,
    output logic             gsr_n,
    output logic             io_en,
    output logic             done_out,
    output logic             abort_pulse,
    output logic             pad_user
);
    localparam int NUM_EV = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    su_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             abort_q;
    logic             pad_s, pad_rise, abort_evt, clear, run, all_out;
    logic [CNT_W-1:0] idx   [NUM_EV];
    logic [NUM_EV-1:0] hit, rel;

    assign idx[0] = idx_gsr;
    assign idx[1] = idx_io;
    assign idx[2] = idx_done;

    pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(rst_pad),
        .pad_s(pad_s), .pad_rise(pad_rise)
    );

    assign run       = (state_q == ST_STARTUP);
    assign abort_evt = pad_rise && (state_q != ST_USER);
    assign clear     = (state_d == ST_CONFIG);
    assign all_out   = &(rel | hit);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_slot
        release_slot #(.CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
            .cnt(cnt_q), .idx(idx[g]), .hit(hit[g]), .released(rel[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG:  if (!abort_evt && cfg_done && !pad_s) state_d = ST_STARTUP;
            ST_STARTUP: if (abort_evt || !cfg_done)           state_d = ST_CONFIG;
                        else if (all_out)                     state_d = ST_USER;
            ST_USER:    if (!cfg_done)                        state_d = ST_CONFIG;
            default:                                          state_d = ST_CONFIG;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    // counter and abort status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_evt;
            if (state_d == ST_CONFIG)
                cnt_q <= '0;
            else if (run && state_d == ST_STARTUP && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    gsr_mux u_gsr (
        .sel(gsr_sel), .released(rel[0]), .pad_s(pad_s),
        .routed(gsr_int), .gsr_n(gsr_n)
    );

    assign io_en       = rel[1];
    assign done_out    = rel[2];
    assign abort_pulse = abort_q;
    assign pad_user    = (gsr_src_e'(gsr_sel) == GSR_PAD) ? 1'b0 : pad_s;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_done,
    input logic [1:0] gsr_sel,
    input logic       gsr_n,
    input logic       io_en,
    input logic       done_out,
    input logic       abort_pulse,
    input logic       pad_user
);
    a_r4_abort_restores: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!io_en && !done_out && !gsr_n));

    a_r4_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    a_r6_io_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(io_en) && $past(cfg_done) && !abort_pulse) |-> io_en);

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_out) && $past(cfg_done) && !abort_pulse) |-> done_out);

    a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_done) |-> (!io_en && !done_out && !gsr_n));

    a_r7_pad_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (gsr_sel == 2'b01) |-> !pad_user);
endmodule

bind startup_seq startup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .gsr_sel(gsr_sel),
    .gsr_n(gsr_n), .io_en(io_en), .done_out(done_out),
    .abort_pulse(abort_pulse), .pad_user(pad_user)
);

// File: tb/test_startup_seq.sv
module test_startup_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_done = 1'b0, rst_pad = 1'b0, gsr_int = 1'b0;
    logic [1:0] gsr_sel = 2'b00;
    logic [2:0] idx_gsr = 3'd0, idx_io = 3'd0, idx_done = 3'd0;
    logic gsr_n, io_en, done_out, abort_pulse, pad_user;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    startup_seq i_startup_seq (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .rst_pad(rst_pad),
        .gsr_sel(gsr_sel), .gsr_int(gsr_int), .idx_gsr(idx_gsr),
        .idx_io(idx_io), .idx_done(idx_done), .gsr_n(gsr_n), .io_en(io_en),
        .done_out(done_out), .abort_pulse(abort_pulse), .pad_user(pad_user)
    );

    // behavioural reference: 0 config, 1 start-up, 2 user
    int m_st = 0, m_cnt = 0;
    bit m_rg, m_ri, m_rd, m_ab, m_s1, m_s2, m_q;
    int abort_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
            {m_rg, m_ri, m_rd, m_ab, m_s1, m_s2, m_q} = '0;
        end else begin
            bit ab, hg, hi, hd;
            int nst;
            ab = m_s2 && !m_q && m_st != 2;
            hg = (m_st == 1) && (m_cnt == int'(idx_gsr));
            hi = (m_st == 1) && (m_cnt == int'(idx_io));
            hd = (m_st == 1) && (m_cnt == int'(idx_done));
            nst = m_st;
            if (m_st == 0 && !ab && cfg_done && !m_s2) nst = 1;
            else if (m_st == 1 && (ab || !cfg_done)) nst = 0;
            else if (m_st == 1 && (m_rg | hg) && (m_ri | hi) && (m_rd | hd)) nst = 2;
            else if (m_st == 2 && !cfg_done) nst = 0;
            if (nst == 0) begin
                m_rg = 0; m_ri = 0; m_rd = 0; m_cnt = 0;
            end else begin
                m_rg |= hg; m_ri |= hi; m_rd |= hd;
                if (m_st == 1 && nst == 1 && m_cnt < 7) m_cnt++;
            end
            m_st = nst;
            m_ab = ab;
            m_q = m_s2; m_s2 = m_s1; m_s1 = rst_pad;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit eg, ep;
            eg = !m_rg ? 1'b0 : (gsr_sel == 2'b01) ? !m_s2 :
                 (gsr_sel == 2'b10) ? !gsr_int : 1'b1;
            ep = (gsr_sel == 2'b01) ? 1'b0 : m_s2;
            chk(gsr_n == eg, "R2 gsr_n", gsr_n, eg);
            chk(io_en == m_ri, "R2 io_en", io_en, m_ri);
            chk(done_out == m_rd, "R2 done_out", done_out, m_rd);
            chk(abort_pulse == m_ab, "R4 abort_pulse", abort_pulse, m_ab);
            chk(pad_user == ep, "R7 pad_user", pad_user, ep);
            if (abort_pulse) abort_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        chk(gsr_n == 0 && io_en == 0 && done_out == 0, "R1 reset state",
            {gsr_n, io_en, done_out}, 0);
        rst_n = 1'b1;
        cyc(3);
        chk({gsr_n, io_en, done_out} == 0, "R1 config hold", {gsr_n, io_en, done_out}, 0);

        // R2 exact timing, index 0 on I/O enable
        idx_gsr = 3'd2; idx_io = 3'd0; idx_done = 3'd5;
        cfg_done = 1'b1;
        cyc(1);
        chk(io_en == 0, "R2 io_en after start edge", io_en, 0);
        cyc(1);
        chk(io_en == 1, "R2 io_en after edge 1", io_en, 1);
        cyc(10);
        chk(done_out == 1 && gsr_n == 1, "R6 user mode held", {done_out, gsr_n}, 3);

        // R7 pad toggles in user mode with pad not selected
        rst_pad = 1'b1; cyc(5);
        chk(io_en == 1 && done_out == 1 && abort_seen == 0, "R7 pad ignored",
            abort_seen, 0);
        chk(pad_user == 1, "R7 pad reported", pad_user, 1);
        rst_pad = 1'b0; cyc(3);

        // R5 pad source
        gsr_sel = 2'b01; rst_pad = 1'b1; cyc(3);
        chk(gsr_n == 0, "R5 pad drives gsr_n", gsr_n, 0);
        rst_pad = 1'b0; cyc(3);
        chk(gsr_n == 1, "R5 pad released gsr_n", gsr_n, 1);

        // R5 routed source
        gsr_sel = 2'b10; gsr_int = 1'b1; cyc(1);
        chk(gsr_n == 0, "R5 routed drives gsr_n", gsr_n, 0);
        gsr_int = 1'b0; cyc(1);
        chk(gsr_n == 1, "R5 routed idle", gsr_n, 1);
        gsr_sel = 2'b11; gsr_int = 1'b1; cyc(1);
        chk(gsr_n == 1, "R5 code 11 disabled", gsr_n, 1);
        gsr_int = 1'b0; gsr_sel = 2'b00;

        // R8 reconfigure from user mode
        cfg_done = 1'b0; cyc(2);
        chk({gsr_n, io_en, done_out} == 0 && abort_seen == 0, "R8 reconfigure",
            {gsr_n, io_en, done_out}, 0);

        // R3 shared indices
        idx_gsr = 3'd3; idx_io = 3'd3; idx_done = 3'd3;
        cfg_done = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            chk(io_en == done_out && gsr_n == io_en, "R3 shared release",
                {gsr_n, io_en, done_out}, {3{io_en}});
        end

        // R4 abort during start-up
        cfg_done = 1'b0; cyc(2);
        idx_gsr = 3'd5; idx_io = 3'd6; idx_done = 3'd7;
        cfg_done = 1'b1; cyc(3);
        abort_seen = 0;
        rst_pad = 1'b1; cyc(8);
        chk(abort_seen == 1, "R4 single abort pulse", abort_seen, 1);
        // R9 pad high holds configuration
        chk({io_en, done_out, gsr_n} == 0, "R9 held by pad", {io_en, done_out, gsr_n}, 0);
        rst_pad = 1'b0; cyc(12);
        chk(done_out == 1 && io_en == 1, "R9 resumes after pad", {done_out, io_en}, 3);

        // R8 withdraw during start-up
        cfg_done = 1'b0; cyc(2); cfg_done = 1'b1; cyc(3);
        abort_seen = 0;
        cfg_done = 1'b0; cyc(2);
        chk({gsr_n, io_en, done_out} == 0 && abort_seen == 0, "R8 withdraw",
            {gsr_n, io_en, done_out}, 0);
        cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule